// File: doc/BRIEF.md
# Soft-Decision Branch Metric Unit

This block serves a convolutional decoder of rate 1/2, 1/3 or 1/4. For each trellis step it receives up to four signed 16-bit soft symbols, plus a table that holds an expected code word for every branch. For each branch it produces one signed 16-bit correlation metric. The branch metrics then go to a path metric unit, which is outside this block.

The correlation needs no multiplier. Each soft symbol passes through unchanged, is negated, or is dropped, depending on the sign of the matching table entry. Each branch then adds its terms in a fixed two-level tree of saturating adders. The same datapath serves all three rates: a rate parameter forces the soft symbol lanes that the code rate does not use to zero. The step is registered once, so results appear one cycle after the input strobe, and a new step may be presented on every cycle.

Top module: `bmu_core`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, `out_valid` is 0 and every metric is 0.
- R2: `out_valid` is high in exactly the cycle after each cycle in which `in_valid` was high. Steps on consecutive cycles each produce a result on consecutive cycles.
- R3: The term for symbol lane k of a branch is one of three values, chosen by the table entry. A positive entry gives the soft symbol, a negative entry gives the negated soft symbol, and a zero entry gives 0. A branch whose four entries are all zero therefore yields metric 0.
- R4: Negating a soft symbol of -32768 gives +32767.
- R5: With RATE=2, a branch metric is the saturating sum of its lane 0 and lane 1 terms. Soft lanes 2 and 3 and the lane 2 and 3 entries have no effect.
- R6: With RATE=4, a branch metric is sat(sat(t0+t1) + sat(t2+t3)), in that pairing.
- R7: With RATE=3, a branch metric is the RATE=4 result with soft lane 3 forced to zero. The lane 3 soft value has no effect.
- R8: Every adder clamps its result to the range -32768..+32767.
- R9: Every branch uses the same soft symbols. Soft lane k is `soft_in[16k+:16]`. Entry k of branch b is `code_tbl[(4b+k)*16+:16]`. The metric of branch b is `metric_out[16b+:16]`.
- R10: In a cycle after one in which `in_valid` was low, `metric_out` keeps its previous value, whatever the other inputs carried.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Strobe: one trellis step is presented this cycle |
| soft_in | input | 64 | Four signed 16-bit soft symbols |
| code_tbl | input | NUM_BR*64 | Four signed 16-bit expected outputs per branch |
| out_valid | output | 1 | Metrics for a new step are on `metric_out` |
| metric_out | output | NUM_BR*16 | One signed 16-bit metric per branch |

## Verification
Two things happen in the same cycle when steps arrive back to back: a new step is captured while the previous step's metrics are on the outputs. The bench provokes this by driving long runs of consecutive strobes, with idle cycles between some of them that carry junk inputs. Each output cycle is compared against the step driven one cycle earlier, or against the held value after an idle cycle. The two saturation levels of the adder tree can also clip in the same step. Sweeps over extreme soft values push a pair sum into its limit and then the final sum into its limit. The results are judged against a pairwise saturating model computed in the bench for each of the three rates.

// File: rtl/bmu_pkg.sv
package bmu_pkg;
    localparam int SYM_W = 16;
    localparam int LANES = 4;

    typedef logic signed [SYM_W-1:0] sym_t;

    localparam sym_t SYM_MAX = {1'b0, {(SYM_W-1){1'b1}}};
    localparam sym_t SYM_MIN = {1'b1, {(SYM_W-1){1'b0}}};

    // Add two symbols, clamping to the signed range.
    function automatic sym_t sat_add(input sym_t a, input sym_t b);
        logic [SYM_W:0] wide;
        wide = {a[SYM_W-1], a} + {b[SYM_W-1], b};
        if (wide[SYM_W] != wide[SYM_W-1])
            return wide[SYM_W] ? SYM_MIN : SYM_MAX;
        return sym_t'(wide[SYM_W-1:0]);
    endfunction

    // Negate, with the most negative value mapped to the most positive.
    function automatic sym_t sat_neg(input sym_t a);
        if (a == SYM_MIN)
            return SYM_MAX;
        return -a;
    endfunction
endpackage

// File: rtl/bmu_term.sv
module bmu_term
    import bmu_pkg::*;
(
    input  sym_t soft_i,
    input  sym_t code_i,
    output sym_t term_o
);
    // Sign-keyed select replaces a multiply.
    always_comb begin
        if (code_i == '0)
            term_o = '0;
        else if (code_i[SYM_W-1])
            term_o = sat_neg(soft_i);
        else
            term_o = soft_i;
    end
endmodule

// File: rtl/bmu_branch.sv
module bmu_branch
    import bmu_pkg::*;
(
    input  logic [LANES*SYM_W-1:0] soft_i,
    input  logic [LANES*SYM_W-1:0] code_i,
    output sym_t                   metric_o
);
    localparam int PAIRS = LANES / 2;

    sym_t term_w [LANES];
    sym_t pair_w [PAIRS];

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        bmu_term i_term (
            .soft_i (sym_t'(soft_i[k*SYM_W +: SYM_W])),
            .code_i (sym_t'(code_i[k*SYM_W +: SYM_W])),
            .term_o (term_w[k])
        );
    end

    // First level: adjacent lanes summed pairwise.
    for (genvar p = 0; p < PAIRS; p++) begin : g_pair
        always_comb pair_w[p] = sat_add(term_w[2*p], term_w[2*p+1]);
    end

    // Second level: the two pair sums.
    always_comb metric_o = sat_add(pair_w[0], pair_w[1]);
endmodule

// File: rtl/bmu_core.sv
module bmu_core
    import bmu_pkg::*;
#(
    parameter int NUM_BR = 8,
    parameter int RATE   = 4
)(
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          in_valid,
    input  logic [LANES*SYM_W-1:0]        soft_in,
    input  logic [NUM_BR*LANES*SYM_W-1:0] code_tbl,
    output logic                          out_valid,
    output logic [NUM_BR*SYM_W-1:0]       metric_out
);
    localparam int USED_LANES = (RATE == 2) ? 2 : ((RATE == 3) ? 3 : 4);
    localparam int STEP_W     = LANES * SYM_W;
    localparam int OUT_W      = NUM_BR * SYM_W;
    localparam logic [STEP_W-1:0] LANE_MASK =
        {STEP_W{1'b1}} >> ((LANES - USED_LANES) * SYM_W);

    typedef struct packed {
        logic             vld;
        logic [OUT_W-1:0] metric;
    } state_t;

    state_t state_d, state_q;

    logic [STEP_W-1:0] soft_eff;
    logic [OUT_W-1:0]  metric_w;

    // Lanes beyond the code rate are zeroed so one datapath serves all rates.
    always_comb soft_eff = soft_in & LANE_MASK;

    for (genvar b = 0; b < NUM_BR; b++) begin : g_br
        bmu_branch i_branch (
            .soft_i   (soft_eff),
            .code_i   (code_tbl[b*STEP_W +: STEP_W]),
            .metric_o (metric_w[b*SYM_W +: SYM_W])
        );
    end

    always_comb begin
        state_d     = state_q;
        state_d.vld = in_valid;
        if (in_valid)
            state_d.metric = metric_w;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= '0;
        else
            state_q <= state_d;
    end

    assign out_valid  = state_q.vld;
    assign metric_out = state_q.metric;
endmodule

// File: rtl/bmu_core_chk.sv
module bmu_core_chk
    import bmu_pkg::*;
#(
    parameter int NUM_BR = 8
)(
    input logic                          clk,
    input logic                          rst_n,
    input logic                          in_valid,
    input logic [NUM_BR*LANES*SYM_W-1:0] code_tbl,
    input logic                          out_valid,
    input logic [NUM_BR*SYM_W-1:0]       metric_out
);
    localparam int STEP_W = LANES * SYM_W;

    // R1: the first cycle after reset release presents an idle, cleared output.
    assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!out_valid && metric_out == '0));

    // R2: the valid strobe is delayed by exactly one cycle.
    assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    assert_no_spurious_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R10: without a strobe the metrics do not move.
    assert_hold_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(metric_out));

    // R3: an all-zero expected word contributes nothing.
    for (genvar b = 0; b < NUM_BR; b++) begin : g_zero
        assert_zero_word_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && code_tbl[b*STEP_W +: STEP_W] == '0)
            |=> metric_out[b*SYM_W +: SYM_W] == '0);
    end
endmodule

bind bmu_core bmu_core_chk #(.NUM_BR(NUM_BR)) i_bmu_core_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .code_tbl   (code_tbl),
    .out_valid  (out_valid),
    .metric_out (metric_out)
);

// File: tb/test_bmu_core.sv
module test_bmu_core;
    import bmu_pkg::*;

    localparam int NB = 8;
    localparam int TW = NB * LANES * SYM_W;
    localparam int OW = NB * SYM_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [LANES*SYM_W-1:0] soft_in = '0;
    logic [TW-1:0] code_tbl = '0;
    logic v2, v3, v4;
    logic [OW-1:0] m2, m3, m4;

    always #10 clk = ~clk;   // 50 MHz

    bmu_core #(.NUM_BR(NB), .RATE(4)) i_bmu_core (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .soft_in(soft_in),
        .code_tbl(code_tbl), .out_valid(v4), .metric_out(m4));
    bmu_core #(.NUM_BR(NB), .RATE(3)) i_bmu_core_r3 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .soft_in(soft_in),
        .code_tbl(code_tbl), .out_valid(v3), .metric_out(m3));
    bmu_core #(.NUM_BR(NB), .RATE(2)) i_bmu_core_r2 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .soft_in(soft_in),
        .code_tbl(code_tbl), .out_valid(v2), .metric_out(m2));

    int errors = 0;
    int checks = 0;
    bit done = 0;
    int soft_v [4];
    int tbl [NB][4];
    int exp2 [NB];
    int exp3 [NB];
    int exp4 [NB];
    bit pend = 0;
    string tag = "";

    function automatic int sat(input int v);
        if (v > 32767) return 32767;
        if (v < -32768) return -32768;
        return v;
    endfunction

    function automatic int term(input int x, input int e);
        if (e > 0) return x;
        if (e < 0) return sat(-x);
        return 0;
    endfunction

    function automatic int model(input int rate, input int b);
        int t0, t1, t2, t3;
        t0 = term(soft_v[0], tbl[b][0]);
        t1 = term(soft_v[1], tbl[b][1]);
        t2 = term(soft_v[2], tbl[b][2]);
        t3 = term(soft_v[3], tbl[b][3]);
        if (rate == 2) return sat(t0 + t1);
        if (rate == 3) return sat(sat(t0 + t1) + t2);
        return sat(sat(t0 + t1) + sat(t2 + t3));
    endfunction

    task automatic chk(input string t, input int act, input int expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", t, act, expv);
        end
    endtask

    task automatic observe();
        string t2, t3, t4;
        t2 = pend ? ((tag == "") ? "R5" : tag) : "R10";
        t3 = pend ? ((tag == "") ? "R7" : tag) : "R10";
        t4 = pend ? ((tag == "") ? "R6" : tag) : "R10";
        chk("R2", int'(v2), int'(pend));
        chk("R2", int'(v3), int'(pend));
        chk("R2", int'(v4), int'(pend));
        for (int b = 0; b < NB; b++) begin
            chk(t2, int'($signed(m2[b*SYM_W +: SYM_W])), exp2[b]);
            chk(t3, int'($signed(m3[b*SYM_W +: SYM_W])), exp3[b]);
            chk(t4, int'($signed(m4[b*SYM_W +: SYM_W])), exp4[b]);
        end
    endtask

    // Drive one cycle at a falling edge, then judge it at the next one.
    task automatic apply(input bit v, input string t);
        for (int k = 0; k < 4; k++) soft_in[k*SYM_W +: SYM_W] = 16'(soft_v[k]);
        for (int b = 0; b < NB; b++)
            for (int k = 0; k < 4; k++)
                code_tbl[(4*b+k)*SYM_W +: SYM_W] = 16'(tbl[b][k]);
        in_valid = v;
        if (v) begin
            for (int b = 0; b < NB; b++) begin
                exp2[b] = model(2, b);
                exp3[b] = model(3, b);
                exp4[b] = model(4, b);
            end
        end
        pend = v;
        tag = t;
        @(negedge clk);
        observe();
    endtask

    task automatic fill(input int s0, input int s1, input int s2, input int s3, input int e);
        soft_v[0] = s0; soft_v[1] = s1; soft_v[2] = s2; soft_v[3] = s3;
        for (int b = 0; b < NB; b++)
            for (int k = 0; k < 4; k++) tbl[b][k] = e;
    endtask

    initial begin
        int vals [8] = '{-32768, -32767, -12000, -1, 0, 1, 23456, 32767};
        int evals [6] = '{-32768, -5, -1, 0, 1, 32767};
        for (int b = 0; b < NB; b++) begin
            exp2[b] = 0; exp3[b] = 0; exp4[b] = 0;
        end
        fill(0, 0, 0, 0, 0);
        repeat (3) @(negedge clk);
        // R1: outputs cleared under reset
        pend = 0; tag = "R1";
        chk("R1", int'(v4), 0);
        chk("R1", int'(v2), 0);
        for (int b = 0; b < NB; b++) chk("R1", int'($signed(m4[b*SYM_W +: SYM_W])), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", int'(v3), 0);
        chk("R1", int'($signed(m3[15:0])), 0);

        // R4: negated most-negative symbol
        fill(-32768, 0, 0, 0, 0);
        for (int b = 0; b < NB; b++) tbl[b][0] = -1;
        apply(1, "R4");
        chk("R4", int'($signed(m2[15:0])), 32767);
        chk("R4", int'($signed(m4[15:0])), 32767);

        // R8: clamping at both limits, both tree levels
        fill(32767, 32767, 32767, 32767, 1);
        apply(1, "R8");
        chk("R8", int'($signed(m4[15:0])), 32767);
        fill(-32768, -32768, -32768, -32768, 1);
        apply(1, "R8");
        chk("R8", int'($signed(m4[15:0])), -32768);
        fill(-32768, -32768, -32768, -32768, -7);
        apply(1, "R8");
        chk("R8", int'($signed(m3[15:0])), 32767);

        // R3: zero entries; branch 2 has an all-zero word
        fill(100, 200, 300, 400, 0);
        for (int b = 0; b < NB; b++)
            for (int k = 0; k < 4; k++) tbl[b][k] = ((b + k) % 3) - 1;
        for (int k = 0; k < 4; k++) tbl[2][k] = 0;
        apply(1, "R3");
        chk("R3", int'($signed(m4[2*SYM_W +: SYM_W])), 0);

        // R9: common soft symbols, per-branch sign patterns
        fill(1000, -2000, 3000, -4000, 0);
        for (int b = 0; b < NB; b++)
            for (int k = 0; k < 4; k++) tbl[b][k] = ((b >> (k % 3)) & 1) ? 3 : -3;
        apply(1, "R9");
        chk("R9", int'($signed(m4[0 +: SYM_W])), -(1000) + 2000 - 3000 + 4000);

        // R7 and R5: unused lanes carry large values and must not matter
        fill(10, 20, 30, 32767, 1);
        apply(1, "R7");
        chk("R7", int'($signed(m3[15:0])), 60);
        chk("R5", int'($signed(m2[15:0])), 30);

        // R10: idle cycle with junk inputs
        fill(12345, -12345, 12345, -12345, 1);
        apply(0, "R10");
        apply(0, "R10");

        // Near-exhaustive sweep: 8^4 soft patterns, rotating tables, some idle gaps.
        for (int n = 0; n < 4096; n++) begin
            if (n % 9 == 4) begin
                fill(-777, 777, -777, 777, -1);
                apply(0, "R10");
            end
            for (int k = 0; k < 4; k++) soft_v[k] = vals[(n >> (3*k)) & 7];
            for (int b = 0; b < NB; b++)
                for (int k = 0; k < 4; k++) tbl[b][k] = evals[(b*3 + k*5 + n) % 6];
            apply(1, "");
        end
        in_valid = 1'b0;
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule